// File: doc/BRIEF.md
# Rotating-Parity Array Small-Write Controller

This block turns one logical block write into the physical accesses needed on an array of `NUM_DISKS` disks protected by one parity block per stripe row. It maps a logical block address to a stripe row, a data disk and the parity disk of that row. It then updates parity without touching the other data blocks of the row. The old data block and the old parity block are read, the new data block is written, and the new parity block is written. The new parity is the word-by-word XOR of the new data, the old data and the old parity.

Parity placement is set by `cfg_rotate`, which is sampled when a request is accepted. When it is high, the parity disk moves by one position on each row, so parity is spread over every disk. When it is low, parity always sits on the highest-numbered disk. Each row holds `NUM_DISKS-1` data blocks. Logical address `lba` lies in row `lba / (NUM_DISKS-1)` at slot `lba % (NUM_DISKS-1)`. The new data comes from a buffer outside the block, which is read one word at a time through `src_idx`/`src_word`.

The disk side is one shared port. A one-hot `dsk_sel` names the disk, and `dsk_req`/`dsk_ack` form a handshake for each word. Only one physical access is in flight at any time. Each access moves `BLK_WORDS` words, sent in ascending index order.

The sequencer has five states. **IDLE** goes to **RD_DATA** on `wr_req`. **RD_DATA** goes to **RD_PAR** on the acknowledge of the last word. **RD_PAR** goes to **WR_DATA** on the acknowledge of the last word. **WR_DATA** goes to **WR_PAR** on the acknowledge of the last word. **WR_PAR** returns to **IDLE** on the acknowledge of the last word and raises `done` for one cycle.

Top module: `stripe_parity_writer`

## Requirements
- R1: While reset is applied and in the first cycle after it, `busy`, `done` and `dsk_req` are low and `dsk_sel` is all zeros.
- R2: `wr_req` is taken only when `busy` is low, and `busy` is high in the cycle after it is taken. A `wr_req`, `wr_lba` or `cfg_rotate` change seen while `busy` is high has no effect on the accesses of the write in progress, and no further write follows from it.
- R3: Each logical write issues four accesses in this fixed order: read of the data disk (`dsk_we`=0), read of the parity disk (`dsk_we`=0), write of the data disk (`dsk_we`=1), write of the parity disk (`dsk_we`=1). Every access steps `dsk_idx` from 0 to `BLK_WORDS-1`, advancing one word on each `dsk_ack`.
- R4: A logical write makes exactly two full-block reads and two full-block writes, and `dsk_req` is low whenever `busy` is low.
- R5: The word written on the parity disk at index i equals `src_word[i]` XOR the old data word i XOR the old parity word i.
- R6: When `cfg_rotate`=1, the parity disk of row r is `(NUM_DISKS-1) - (r mod NUM_DISKS)`.
- R7: The data disk is the slot-th disk in ascending order, counting from 0 and skipping the parity disk of the row.
- R8: When `cfg_rotate`=0, the parity disk is `NUM_DISKS-1` for every row, so the data disk equals the slot.
- R9: `done` is high for exactly one cycle, the cycle after the last word of the parity write is acknowledged. `busy` is low in that same cycle, and a `wr_req` held high in that cycle starts the next write.
- R10: While `dsk_req` is high, exactly one bit of `dsk_sel` is set. With no `dsk_ack`, `dsk_sel`, `dsk_we`, `dsk_row` and `dsk_idx` hold their values into the next cycle. While `dsk_req` is low, `dsk_sel` is zero.
- R11: The word written on the data disk at index i equals `src_word` read at `src_idx`=i.
- R12: `dsk_row` carries the stripe row `wr_lba / (NUM_DISKS-1)` of the accepted request for all four accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| cfg_rotate | input | 1 | 1: parity rotates by row, 0: parity on the last disk; sampled on acceptance |
| wr_req | input | 1 | Logical write request |
| wr_lba | input | LBA_W | Logical block address of the request |
| busy | output | 1 | A logical write is in progress |
| done | output | 1 | One-cycle pulse when the parity write completes |
| src_idx | output | IDX_W | Word index into the new-data source buffer |
| src_word | input | WORD_W | New-data word at `src_idx` |
| dsk_req | output | 1 | Disk word access request |
| dsk_we | output | 1 | 1 write, 0 read |
| dsk_sel | output | NUM_DISKS | One-hot disk select |
| dsk_row | output | LBA_W | Stripe row (block address on the disk) |
| dsk_idx | output | IDX_W | Word index within the block |
| dsk_wdata | output | WORD_W | Write data word |
| dsk_rdata | input | WORD_W | Read data word, valid with `dsk_ack` |
| dsk_ack | input | 1 | Word acknowledge |

## Verification
Some behaviour is checked by the assertions on every cycle. These checks cover the one-hot select, the access address holding steady while an acknowledge is pending, the single-cycle `done` with `busy` low, the start of `busy` after an accepted request, and the absence of disk requests while idle. Other behaviour only the bench scenarios can show, against a behavioural model of the array. That covers the placement arithmetic for rotating and fixed parity, including rows whose parity lands on disk 0. It also covers the ordering of the four accesses, the XOR contents of the parity block, and the proof that requests and configuration changes made mid-write are ignored.

// File: rtl/psw_pkg.sv
package psw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RD_DATA = 3'd1,
        ST_RD_PAR  = 3'd2,
        ST_WR_DATA = 3'd3,
        ST_WR_PAR  = 3'd4
    } psw_state_e;

    function automatic logic phase_on_parity(psw_state_e s);
        return (s == ST_RD_PAR) || (s == ST_WR_PAR);
    endfunction

    function automatic logic phase_writes(psw_state_e s);
        return (s == ST_WR_DATA) || (s == ST_WR_PAR);
    endfunction

endpackage

// File: rtl/psw_map.sv
module psw_map #(
    parameter int NUM_DISKS = 4,
    parameter int LBA_W     = 12,
    localparam int DSK_W    = $clog2(NUM_DISKS)
) (
    input  logic [LBA_W-1:0] lba,
    input  logic             rotate,
    output logic [LBA_W-1:0] row,
    output logic [DSK_W-1:0] data_disk,
    output logic [DSK_W-1:0] par_disk
);
    localparam int DATA_DISKS = NUM_DISKS - 1;
    localparam logic [DSK_W-1:0] LAST_DISK = DSK_W'(NUM_DISKS - 1);

    logic [DSK_W-1:0] slot;
    logic [DSK_W-1:0] shift;

    // stripe row and position of the block within the row
    assign row   = lba / LBA_W'(DATA_DISKS);
    assign slot  = DSK_W'(lba % LBA_W'(DATA_DISKS));
    assign shift = DSK_W'(row % LBA_W'(NUM_DISKS));

    // parity moves one disk down per row when rotating
    assign par_disk = rotate ? (LAST_DISK - shift) : LAST_DISK;

    // data slots fill the remaining disks in ascending order
    assign data_disk = (slot < par_disk) ? slot : (slot + DSK_W'(1));

endmodule

// File: rtl/psw_wordbuf.sv
module psw_wordbuf #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem[rd_idx];

endmodule

// File: rtl/psw_seq.sv
module psw_seq
    import psw_pkg::*;
#(
    parameter int BLK_WORDS = 16,
    localparam int IDX_W    = $clog2(BLK_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_req,
    input  logic             dsk_ack,
    output psw_state_e       state,
    output logic [IDX_W-1:0] idx,
    output logic             done,
    output logic             accept,
    output logic             busy,
    output logic             dsk_req,
    output logic             dsk_we,
    output logic             on_parity,
    output logic             cap_data,
    output logic             cap_par,
    output logic             xor_mode
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BLK_WORDS - 1);

    psw_state_e state_nx;
    logic       last_word;
    logic       step;

    assign last_word = (idx == LAST_IDX);
    assign step      = dsk_ack && (state != ST_IDLE);

    // next-state decode
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (wr_req)                state_nx = ST_RD_DATA;
            ST_RD_DATA: if (dsk_ack && last_word)  state_nx = ST_RD_PAR;
            ST_RD_PAR:  if (dsk_ack && last_word)  state_nx = ST_WR_DATA;
            ST_WR_DATA: if (dsk_ack && last_word)  state_nx = ST_WR_PAR;
            ST_WR_PAR:  if (dsk_ack && last_word)  state_nx = ST_IDLE;
            default:                               state_nx = ST_IDLE;
        endcase
    end

    // state register, word counter and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
            done  <= 1'b0;
        end else begin
            state <= state_nx;
            done  <= (state == ST_WR_PAR) && dsk_ack && last_word;
            if (state == ST_IDLE) begin
                idx <= '0;
            end else if (step) begin
                idx <= last_word ? '0 : (idx + IDX_W'(1));
            end
        end
    end

    // outputs decoded from the current state
    always_comb begin
        accept    = 1'b0;
        busy      = 1'b1;
        dsk_req   = 1'b1;
        dsk_we    = phase_writes(state);
        on_parity = phase_on_parity(state);
        cap_data  = 1'b0;
        cap_par   = 1'b0;
        xor_mode  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                accept  = wr_req;
                busy    = 1'b0;
                dsk_req = 1'b0;
                dsk_we  = 1'b0;
            end
            ST_RD_DATA: cap_data = dsk_ack;
            ST_RD_PAR:  cap_par  = dsk_ack;
            ST_WR_DATA: xor_mode = 1'b0;
            ST_WR_PAR:  xor_mode = 1'b1;
            default: begin
                busy    = 1'b0;
                dsk_req = 1'b0;
                dsk_we  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/stripe_parity_writer.sv
module stripe_parity_writer
    import psw_pkg::*;
#(
    parameter int NUM_DISKS = 4,
    parameter int WORD_W    = 32,
    parameter int BLK_WORDS = 16,
    parameter int LBA_W     = 12,
    localparam int DSK_W    = $clog2(NUM_DISKS),
    localparam int IDX_W    = $clog2(BLK_WORDS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_rotate,
    input  logic                 wr_req,
    input  logic [LBA_W-1:0]     wr_lba,
    output logic                 busy,
    output logic                 done,
    output logic [IDX_W-1:0]     src_idx,
    input  logic [WORD_W-1:0]    src_word,
    output logic                 dsk_req,
    output logic                 dsk_we,
    output logic [NUM_DISKS-1:0] dsk_sel,
    output logic [LBA_W-1:0]     dsk_row,
    output logic [IDX_W-1:0]     dsk_idx,
    output logic [WORD_W-1:0]    dsk_wdata,
    input  logic [WORD_W-1:0]    dsk_rdata,
    input  logic                 dsk_ack
);
    localparam int NUM_BUFS = 2;

    psw_state_e       state;
    logic [IDX_W-1:0] idx;
    logic             accept;
    logic             on_parity;
    logic             cap_data;
    logic             cap_par;
    logic             xor_mode;

    logic [LBA_W-1:0] map_row;
    logic [DSK_W-1:0] map_dd;
    logic [DSK_W-1:0] map_pd;

    logic [LBA_W-1:0] row_q;
    logic [DSK_W-1:0] dd_q;
    logic [DSK_W-1:0] pd_q;
    logic [DSK_W-1:0] tgt_disk;

    logic [NUM_BUFS-1:0] cap_vec;
    logic [WORD_W-1:0]   old_word [NUM_BUFS];

    psw_map #(
        .NUM_DISKS (NUM_DISKS),
        .LBA_W     (LBA_W)
    ) u_map (
        .lba       (wr_lba),
        .rotate    (cfg_rotate),
        .row       (map_row),
        .data_disk (map_dd),
        .par_disk  (map_pd)
    );

    psw_seq #(
        .BLK_WORDS (BLK_WORDS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_req    (wr_req),
        .dsk_ack   (dsk_ack),
        .state     (state),
        .idx       (idx),
        .done      (done),
        .accept    (accept),
        .busy      (busy),
        .dsk_req   (dsk_req),
        .dsk_we    (dsk_we),
        .on_parity (on_parity),
        .cap_data  (cap_data),
        .cap_par   (cap_par),
        .xor_mode  (xor_mode)
    );

    // placement is frozen when a request is taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            dd_q  <= '0;
            pd_q  <= '0;
        end else if (accept) begin
            row_q <= map_row;
            dd_q  <= map_dd;
            pd_q  <= map_pd;
        end
    end

    // old-data buffer (0) and old-parity buffer (1)
    assign cap_vec[0] = cap_data;
    assign cap_vec[1] = cap_par;

    for (genvar b = 0; b < NUM_BUFS; b++) begin : g_oldbuf
        psw_wordbuf #(
            .WORD_W (WORD_W),
            .DEPTH  (BLK_WORDS)
        ) u_buf (
            .clk     (clk),
            .wr_en   (cap_vec[b]),
            .wr_idx  (idx),
            .wr_data (dsk_rdata),
            .rd_idx  (idx),
            .rd_data (old_word[b])
        );
    end

    assign tgt_disk = on_parity ? pd_q : dd_q;

    for (genvar d = 0; d < NUM_DISKS; d++) begin : g_sel
        assign dsk_sel[d] = dsk_req && (tgt_disk == DSK_W'(d));
    end

    assign dsk_row = row_q;
    assign dsk_idx = idx;
    assign src_idx = idx;

    // word-serial parity update
    always_comb begin
        if (!dsk_we) begin
            dsk_wdata = '0;
        end else if (xor_mode) begin
            dsk_wdata = src_word ^ old_word[0] ^ old_word[1];
        end else begin
            dsk_wdata = src_word;
        end
    end

endmodule

// File: rtl/stripe_parity_writer_chk.sv
module stripe_parity_writer_chk #(
    parameter int NUM_DISKS = 4,
    parameter int BLK_WORDS = 16,
    parameter int LBA_W     = 12,
    localparam int IDX_W    = $clog2(BLK_WORDS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_req,
    input logic                 busy,
    input logic                 done,
    input logic                 dsk_req,
    input logic                 dsk_we,
    input logic [NUM_DISKS-1:0] dsk_sel,
    input logic [LBA_W-1:0]     dsk_row,
    input logic [IDX_W-1:0]     dsk_idx,
    input logic                 dsk_ack
);

    // R10
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dsk_req |-> ($countones(dsk_sel) == 1));

    // R10
    sel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dsk_req |-> (dsk_sel == '0));

    // R10
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dsk_req && !dsk_ack) |=> (dsk_req && $stable(dsk_sel) && $stable(dsk_we)
                                   && $stable(dsk_row) && $stable(dsk_idx)));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R2
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_req) |=> busy);

    // R4
    idle_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !dsk_req);

endmodule

bind stripe_parity_writer stripe_parity_writer_chk #(
    .NUM_DISKS (NUM_DISKS),
    .BLK_WORDS (BLK_WORDS),
    .LBA_W     (LBA_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_req  (wr_req),
    .busy    (busy),
    .done    (done),
    .dsk_req (dsk_req),
    .dsk_we  (dsk_we),
    .dsk_sel (dsk_sel),
    .dsk_row (dsk_row),
    .dsk_idx (dsk_idx),
    .dsk_ack (dsk_ack)
);

// File: tb/stripe_parity_writer_bench.sv
module stripe_parity_writer_bench;
    localparam int N     = 4;
    localparam int W     = 32;
    localparam int BW    = 16;
    localparam int LW    = 12;
    localparam int ROWS  = 32;
    localparam int IW    = $clog2(BW);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_rotate = 1'b1;
    logic          wr_req = 1'b0;
    logic [LW-1:0] wr_lba = '0;
    logic          busy, done;
    logic [IW-1:0] src_idx;
    logic [W-1:0]  src_word;
    logic          dsk_req, dsk_we;
    logic [N-1:0]  dsk_sel;
    logic [LW-1:0] dsk_row;
    logic [IW-1:0] dsk_idx;
    logic [W-1:0]  dsk_wdata;
    logic [W-1:0]  dsk_rdata = '0;
    logic          dsk_ack = 1'b0;

    logic [W-1:0] src_buf [BW];
    logic [W-1:0] disk_mem [N][ROWS][BW];

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit fast_ack = 1'b1;
    bit finished = 1'b0;

    // behavioural model state
    bit       m_busy, m_done, m_rot;
    int       m_phase, m_word, m_row, m_dd, m_pd;
    int       m_rd_blocks, m_wr_blocks;
    logic [W-1:0] m_od [BW];
    logic [W-1:0] m_op [BW];

    assign src_word = src_buf[src_idx];

    always #5 clk = ~clk;

    stripe_parity_writer #(
        .NUM_DISKS (N), .WORD_W (W), .BLK_WORDS (BW), .LBA_W (LW)
    ) u_stripe_parity_writer (
        .clk (clk), .rst_n (rst_n), .cfg_rotate (cfg_rotate),
        .wr_req (wr_req), .wr_lba (wr_lba), .busy (busy), .done (done),
        .src_idx (src_idx), .src_word (src_word),
        .dsk_req (dsk_req), .dsk_we (dsk_we), .dsk_sel (dsk_sel),
        .dsk_row (dsk_row), .dsk_idx (dsk_idx), .dsk_wdata (dsk_wdata),
        .dsk_rdata (dsk_rdata), .dsk_ack (dsk_ack)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    task automatic wrap_up();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // cycle model: compare, then decide the disk reply and advance
    always @(negedge clk) begin
        cycles++;
        if (!rst_n) begin
            chk(!busy && !done && !dsk_req && dsk_sel == '0, "R1",
                {busy, done, dsk_req, dsk_sel}, 0);
            m_busy = 0; m_done = 0; m_rd_blocks = 0; m_wr_blocks = 0;
            dsk_ack = 1'b0;
        end else begin
            int cur;
            int exp_disk;
            logic [W-1:0] exp_w;
            bit ack;
            chk(busy == m_busy, "R2", busy, m_busy);
            chk(done == m_done, "R9", done, m_done);
            chk(dsk_req == m_busy, "R4", dsk_req, m_busy);
            if (!m_busy) chk(dsk_sel == '0, "R10", dsk_sel, 0);
            cur = -1;
            for (int d = 0; d < N; d++) if (dsk_sel[d]) cur = d;
            exp_disk = (m_phase == 1 || m_phase == 3) ? m_pd : m_dd;
            exp_w = (m_phase == 3) ? (src_buf[m_word] ^ m_od[m_word] ^ m_op[m_word])
                                   : src_buf[m_word];
            if (m_busy) begin
                chk($countones(dsk_sel) == 1, "R10", dsk_sel, 1);
                chk(dsk_we == (m_phase >= 2), "R3", dsk_we, m_phase >= 2);
                chk(dsk_idx == IW'(m_word), "R3", dsk_idx, m_word);
                chk(dsk_row == LW'(m_row), "R12", dsk_row, m_row);
                if (exp_disk == m_dd)
                    chk(cur == exp_disk, "R7", cur, exp_disk);
                else if (m_rot)
                    chk(cur == exp_disk, "R6", cur, exp_disk);
                else
                    chk(cur == exp_disk, "R8", cur, exp_disk);
                if (m_phase == 2) begin
                    chk(src_idx == IW'(m_word), "R11", src_idx, m_word);
                    chk(dsk_wdata == exp_w, "R11", dsk_wdata, exp_w);
                end
                if (m_phase == 3)
                    chk(dsk_wdata == exp_w, "R5", dsk_wdata, exp_w);
            end
            // disk reply for the coming edge
            ack = m_busy && (fast_ack || ($urandom % 3 != 0));
            dsk_ack = ack;
            dsk_rdata = (cur >= 0 && int'(dsk_row) < ROWS) ? disk_mem[cur][dsk_row][dsk_idx] : '0;
            if (ack && dsk_idx == IW'(BW - 1)) begin
                if (dsk_we) m_wr_blocks++; else m_rd_blocks++;
            end
            if (m_done) begin
                chk(m_rd_blocks == 2 && m_wr_blocks == 2, "R4",
                    {m_rd_blocks[7:0], m_wr_blocks[7:0]}, 16'h0202);
                m_rd_blocks = 0; m_wr_blocks = 0;
            end
            m_done = 0;
            if (m_busy && ack) begin
                if (m_phase >= 2) disk_mem[exp_disk][m_row][m_word] = exp_w;
                if (m_word == BW - 1) begin
                    m_word = 0;
                    if (m_phase == 3) begin m_busy = 0; m_done = 1; end
                    else m_phase++;
                end else m_word++;
            end else if (!m_busy && wr_req) begin
                int slot;
                m_rot = cfg_rotate;
                m_row = int'(wr_lba) / (N - 1);
                slot  = int'(wr_lba) % (N - 1);
                m_pd  = m_rot ? (N - 1) - (m_row % N) : N - 1;
                m_dd  = (slot < m_pd) ? slot : slot + 1;
                for (int w = 0; w < BW; w++) begin
                    m_od[w] = disk_mem[m_dd][m_row][w];
                    m_op[w] = disk_mem[m_pd][m_row][w];
                end
                m_busy = 1; m_phase = 0; m_word = 0;
            end
        end
    end

    always @(posedge clk) begin
        if (cycles > 150000 && !finished) begin
            errors++;
            $display("FAIL watchdog expired");
            wrap_up();
        end
    end

    task automatic fill_src(input int seed);
        for (int w = 0; w < BW; w++) src_buf[w] = $urandom ^ (seed * 32'h01010101);
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!done);
    endtask

    task automatic do_write(input int lba, input bit rot, input bit fast);
        fill_src(lba);
        fast_ack = fast;
        @(posedge clk); #2;
        wr_lba = LW'(lba); cfg_rotate = rot; wr_req = 1'b1;
        @(posedge clk); #2;
        wr_req = 1'b0;
        wait_done();
    endtask

    initial begin
        for (int d = 0; d < N; d++)
            for (int r = 0; r < ROWS; r++)
                for (int w = 0; w < BW; w++)
                    disk_mem[d][r][w] = 32'h9E3779B9 * (d * 1000 + r * 20 + w + 1);
        fill_src(0);
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;
        repeat (3) @(posedge clk);

        // R6 R7: row 0 (parity on 3), row 1 (parity on 2, skip), row 3 (parity on 0), row 4 wraps
        do_write(0, 1'b1, 1'b1);
        do_write(4, 1'b1, 1'b0);
        do_write(5, 1'b1, 1'b0);
        do_write(9, 1'b1, 1'b1);
        do_write(11, 1'b1, 1'b0);
        do_write(12, 1'b1, 1'b0);
        // R8: fixed placement
        do_write(4, 1'b0, 1'b1);
        do_write(11, 1'b0, 1'b0);
        // R5: second update of the same block uses the new parity
        do_write(0, 1'b1, 1'b0);

        // R2: request and configuration change while busy are ignored
        fill_src(77);
        fast_ack = 1'b0;
        @(posedge clk); #2;
        wr_lba = 12'd7; cfg_rotate = 1'b1; wr_req = 1'b1;
        @(posedge clk); #2;
        wr_req = 1'b0;
        repeat (20) @(posedge clk);
        #2 wr_lba = 12'd2; cfg_rotate = 1'b0; wr_req = 1'b1;
        @(posedge clk); #2 wr_req = 1'b0;
        wait_done();
        repeat (6) @(posedge clk);

        // R9: request held high restarts in the done cycle
        fill_src(91);
        fast_ack = 1'b1;
        @(posedge clk); #2;
        wr_lba = 12'd10; cfg_rotate = 1'b1; wr_req = 1'b1;
        wait_done();
        @(posedge clk); #2 wr_req = 1'b0;
        wait_done();

        for (int i = 0; i < 12; i++)
            do_write($urandom % 60, 1'($urandom % 2), 1'($urandom % 2));

        repeat (5) @(posedge clk);
        wrap_up();
    end

endmodule